// File: doc/BRIEF.md
# SD Card Single-Block Write Sequencer

This block is the host-side control sequencer for one single-block write to an SD card. Software presents a transfer length in bytes, a block-size code and a card data address, then pulses a start input. The sequencer captures those values and asks the command unit to send the write-block command, which expects a short response. It then waits for the response-received indication.

The data phase stays closed until that indication arrives. The sequencer then enables the data unit for a host-to-card transfer in block mode and raises a DMA request. Each DMA acknowledge accounts for one fixed burst of words. The sequence finishes on the data unit's end-of-block flag, or ends with an error status on a command or data fault.

The block drives only abstract handshakes. Line serialization, CRC generation and clock division belong to the neighbouring command and data units.

Top module: `sdw_seq_top`

## Requirements
- R1: A start pulse seen while idle raises busy on the next cycle. In that cycle it also raises a one-cycle command request with index 24, the short-response flag set and the argument equal to the address sampled with the start.
- R2: The data enable stays low while the command response is awaited. The cycle after the response-received input is high (with no command fault in the same cycle), the data enable is high, the direction output reads 1 (controller to card) and the block-mode output reads 1.
- R3: The block-size output equals 2^n bytes for block-size code n (code 9 gives 512).
- R4: Length, code and address are sampled only on an accepted start; changes on those inputs while busy do not alter the command argument, the length output or the block-size output.
- R5: In the data phase, the DMA request is high while words remain outstanding. The word count is ceil(length/4). Each acknowledge taken while the request is high removes 4 words, saturating at zero. The burst-size output reads 4, and the request is low outside the data phase.
- R6: Done is a one-cycle pulse issued only on the cycle after the end-of-block input is seen in the data phase. Busy is low in that same cycle.
- R7: A command timeout or CRC fault while the response is awaited gives a one-cycle error pulse and returns to idle without ever enabling data. The error code reads 1 for a timeout (which wins when both occur) and 2 for a CRC fault. A fault also wins over a response in the same cycle.
- R8: A data timeout or CRC error in the data phase gives a one-cycle error pulse with error code 3, and the DMA request is low on the next cycle. A fault in the same cycle as end-of-block wins, and no done pulse is produced.
- R9: A start pulse while busy is ignored: no new command request is issued and the sequence in progress continues unchanged.
- R10: After reset the block is idle. Busy, done, error, command request, data enable and DMA request are low, and the error code reads 0. The error code is held until the next accepted start, which clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| cfg_len_i | input | 16 | Transfer length in bytes |
| cfg_blk_code_i | input | 4 | Block-size code n (2^n bytes) |
| cfg_addr_i | input | 32 | Card data address |
| cmd_valid_o | output | 1 | Command request to command unit |
| cmd_index_o | output | 6 | Command index (24 while requesting) |
| cmd_short_resp_o | output | 1 | Short response expected |
| cmd_arg_o | output | 32 | Command argument (captured address) |
| cmd_resp_rcvd_i | input | 1 | Response received |
| cmd_timeout_i | input | 1 | Command response timeout |
| cmd_crc_fail_i | input | 1 | Command response CRC failure |
| dat_enable_o | output | 1 | Data path enable |
| dat_to_card_o | output | 1 | Direction, 1 = controller to card |
| dat_block_mode_o | output | 1 | 1 = block transfer mode |
| dat_len_o | output | 16 | Captured transfer length |
| dat_blk_bytes_o | output | 16 | Block size in bytes |
| dat_blk_end_i | input | 1 | Data block end flag |
| dat_timeout_i | input | 1 | Data timeout |
| dat_crc_err_i | input | 1 | Data CRC error |
| dma_req_o | output | 1 | DMA request |
| dma_burst_words_o | output | 3 | Words per DMA burst (4) |
| dma_ack_i | input | 1 | One burst delivered |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Successful completion pulse |
| error_o | output | 1 | Error completion pulse |
| err_code_o | output | 2 | 0 none, 1 cmd timeout, 2 cmd CRC, 3 data fault |

## Verification
Two pairs of events can land in the same cycle: a completion flag and a fault, and a command response and a command fault. The bench drives the end-of-block flag together with a data CRC error, and the response-received input together with a command timeout. It expects an error pulse with the proper code, no done pulse, and no data enable in the command case. A start pulse is also driven during the data phase, alongside altered configuration inputs, and the outputs must carry on unchanged.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
    localparam int LEN_W   = 16;
    localparam int ADDR_W  = 32;
    localparam int CODE_W  = 4;
    localparam int BYTES_W = 1 << CODE_W;
    localparam int WORDS_W = LEN_W - 1;
    localparam int BURST_WORDS = 4;
    localparam logic [5:0] WRITE_BLOCK_IDX = 6'd24;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_RESP = 2'd2,
        ST_DATA = 2'd3
    } sdw_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_CMD_TMO = 2'd1,
        ERR_CMD_CRC = 2'd2,
        ERR_DATA    = 2'd3
    } sdw_err_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [CODE_W-1:0] code;
    } sdw_cfg_t;

    function automatic logic [BYTES_W-1:0] code_to_bytes(input logic [CODE_W-1:0] c);
        return BYTES_W'(1) << c;
    endfunction

    function automatic logic [WORDS_W-1:0] len_to_words(input logic [LEN_W-1:0] n);
        logic [LEN_W:0] s;
        s = {1'b0, n} + (LEN_W+1)'(3);
        return WORDS_W'(s >> 2);
    endfunction
endpackage

// File: rtl/sdw_cfg_hold.sv
module sdw_cfg_hold
    import sdw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                capture,
    input  sdw_cfg_t            cfg_in,
    output sdw_cfg_t            cfg_q,
    output logic [BYTES_W-1:0]  blk_bytes
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (capture)
            cfg_q <= cfg_in;
    end

    assign blk_bytes = code_to_bytes(cfg_q.code);

    // R4: held configuration only moves on a capture
    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(cfg_q));
endmodule

// File: rtl/sdw_ctrl_fsm.sv
module sdw_ctrl_fsm
    import sdw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       resp_rcvd,
    input  logic       cmd_tmo,
    input  logic       cmd_crc,
    input  logic       blk_end,
    input  logic       dat_tmo,
    input  logic       dat_crc,
    output logic       capture,
    output logic       enter_data,
    output sdw_state_e state,
    output logic       done,
    output logic       error,
    output sdw_err_e   err_code
);
    sdw_state_e nxt;
    logic cmd_fault, dat_fault;

    assign cmd_fault  = cmd_tmo | cmd_crc;
    assign dat_fault  = dat_tmo | dat_crc;
    assign capture    = (state == ST_IDLE) && start;
    assign enter_data = (state == ST_RESP) && resp_rcvd && !cmd_fault;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_CMD;
            ST_CMD:  nxt = ST_RESP;
            ST_RESP: begin
                if (cmd_fault)      nxt = ST_IDLE;
                else if (resp_rcvd) nxt = ST_DATA;
            end
            ST_DATA: if (dat_fault || blk_end) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            error    <= 1'b0;
            err_code <= ERR_NONE;
        end else begin
            state <= nxt;
            done  <= 1'b0;
            error <= 1'b0;
            if (capture)
                err_code <= ERR_NONE;
            if (state == ST_RESP && cmd_fault) begin
                error    <= 1'b1;
                err_code <= cmd_tmo ? ERR_CMD_TMO : ERR_CMD_CRC;
            end
            if (state == ST_DATA) begin
                if (dat_fault) begin
                    error    <= 1'b1;
                    err_code <= ERR_DATA;
                end else if (blk_end) begin
                    done <= 1'b1;
                end
            end
        end
    end

    // R6: done only follows an observed block end
    p_done_after_end_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(blk_end) && !$past(dat_fault));
    // R7: a command fault never opens the data phase
    p_cmd_fault_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RESP && cmd_fault) |=> (error && state == ST_IDLE));
    // R9: start while busy issues no new command
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && start) |=> state != ST_CMD);
    // R6/R8: completion pulses are exclusive
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(done && error));
endmodule

// File: rtl/sdw_dma_pacer.sv
module sdw_dma_pacer
    import sdw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             active,
    input  logic             ack,
    output logic             req
);
    logic [WORDS_W-1:0] words_left;

    always_ff @(posedge clk) begin
        if (rst)
            words_left <= '0;
        else if (load)
            words_left <= len_to_words(len);
        else if (req && ack) begin
            if (words_left > WORDS_W'(BURST_WORDS))
                words_left <= words_left - WORDS_W'(BURST_WORDS);
            else
                words_left <= '0;
        end
    end

    assign req = active && (words_left != '0);

    // R5: request never outlives the data phase
    p_req_in_data_r5: assert property (@(posedge clk) disable iff (rst)
        req |-> active);
    // R5: the outstanding count only shrinks between loads
    p_words_down_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && !$past(load)) |-> words_left <= $past(words_left));
endmodule

// File: rtl/sdw_seq_top.sv
module sdw_seq_top
    import sdw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [LEN_W-1:0]   cfg_len_i,
    input  logic [CODE_W-1:0]  cfg_blk_code_i,
    input  logic [ADDR_W-1:0]  cfg_addr_i,
    output logic               cmd_valid_o,
    output logic [5:0]         cmd_index_o,
    output logic               cmd_short_resp_o,
    output logic [ADDR_W-1:0]  cmd_arg_o,
    input  logic               cmd_resp_rcvd_i,
    input  logic               cmd_timeout_i,
    input  logic               cmd_crc_fail_i,
    output logic               dat_enable_o,
    output logic               dat_to_card_o,
    output logic               dat_block_mode_o,
    output logic [LEN_W-1:0]   dat_len_o,
    output logic [BYTES_W-1:0] dat_blk_bytes_o,
    input  logic               dat_blk_end_i,
    input  logic               dat_timeout_i,
    input  logic               dat_crc_err_i,
    output logic               dma_req_o,
    output logic [2:0]         dma_burst_words_o,
    input  logic               dma_ack_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               error_o,
    output logic [1:0]         err_code_o
);
    sdw_cfg_t   cfg_in, cfg_q;
    sdw_state_e state;
    sdw_err_e   err_code;
    logic       capture, enter_data, in_data;

    assign cfg_in = '{addr: cfg_addr_i, len: cfg_len_i, code: cfg_blk_code_i};

    sdw_cfg_hold u_cfg (
        .clk(clk), .rst(rst), .capture(capture), .cfg_in(cfg_in),
        .cfg_q(cfg_q), .blk_bytes(dat_blk_bytes_o)
    );

    sdw_ctrl_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start_i),
        .resp_rcvd(cmd_resp_rcvd_i), .cmd_tmo(cmd_timeout_i), .cmd_crc(cmd_crc_fail_i),
        .blk_end(dat_blk_end_i), .dat_tmo(dat_timeout_i), .dat_crc(dat_crc_err_i),
        .capture(capture), .enter_data(enter_data), .state(state),
        .done(done_o), .error(error_o), .err_code(err_code)
    );

    assign in_data = (state == ST_DATA);

    sdw_dma_pacer u_dma (
        .clk(clk), .rst(rst), .load(enter_data), .len(cfg_q.len),
        .active(in_data), .ack(dma_ack_i), .req(dma_req_o)
    );

    assign busy_o            = (state != ST_IDLE);
    assign cmd_valid_o       = (state == ST_CMD);
    assign cmd_index_o       = cmd_valid_o ? WRITE_BLOCK_IDX : 6'd0;
    assign cmd_short_resp_o  = cmd_valid_o;
    assign cmd_arg_o         = cfg_q.addr;
    assign dat_enable_o      = in_data;
    assign dat_to_card_o     = in_data;
    assign dat_block_mode_o  = in_data;
    assign dat_len_o         = cfg_q.len;
    assign dma_burst_words_o = 3'(BURST_WORDS);
    assign err_code_o        = err_code;

    // R1: command request is a single-cycle pulse
    p_cmd_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |=> !cmd_valid_o);
    // R2: data opens only after a clean response
    p_data_after_resp_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(dat_enable_o) |-> $past(cmd_resp_rcvd_i) && !$past(cmd_timeout_i || cmd_crc_fail_i));
    // R8: a data fault drops the DMA request next cycle
    p_fault_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (dat_enable_o && (dat_timeout_i || dat_crc_err_i)) |=> (!dma_req_o && error_o));
endmodule

// File: tb/tb_sdw_seq_top.sv
module tb_sdw_seq_top;
    logic        clk = 0, rst;
    logic        start_i;
    logic [15:0] cfg_len_i;
    logic [3:0]  cfg_blk_code_i;
    logic [31:0] cfg_addr_i;
    logic        cmd_valid_o, cmd_short_resp_o;
    logic [5:0]  cmd_index_o;
    logic [31:0] cmd_arg_o;
    logic        cmd_resp_rcvd_i, cmd_timeout_i, cmd_crc_fail_i;
    logic        dat_enable_o, dat_to_card_o, dat_block_mode_o;
    logic [15:0] dat_len_o, dat_blk_bytes_o;
    logic        dat_blk_end_i, dat_timeout_i, dat_crc_err_i;
    logic        dma_req_o, dma_ack_i;
    logic [2:0]  dma_burst_words_o;
    logic        busy_o, done_o, error_o;
    logic [1:0]  err_code_o;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sdw_seq_top dut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_words(input int len);
        return (len + 3) / 4;
    endfunction
    function automatic int exp_bytes(input int code);
        return 1 << code;
    endfunction

    task automatic idle_inputs();
        start_i = 0; cmd_resp_rcvd_i = 0; cmd_timeout_i = 0; cmd_crc_fail_i = 0;
        dat_blk_end_i = 0; dat_timeout_i = 0; dat_crc_err_i = 0; dma_ack_i = 0;
    endtask

    // Starts a write and checks the command cycle; leaves bench in response wait.
    task automatic begin_write(input int len, input int code, input int addr);
        @(negedge clk);
        start_i = 1; cfg_len_i = 16'(len); cfg_blk_code_i = 4'(code); cfg_addr_i = 32'(addr);
        @(negedge clk);
        start_i = 0;
        cfg_len_i = ~cfg_len_i; cfg_blk_code_i = cfg_blk_code_i ^ 4'h3; cfg_addr_i = ~cfg_addr_i;
        chk(busy_o, "R1 busy", busy_o, 1);
        chk(cmd_valid_o && cmd_index_o == 6'd24 && cmd_short_resp_o, "R1 cmd", cmd_index_o, 24);
        chk(cmd_arg_o == 32'(addr), "R1 arg", cmd_arg_o, addr);
        chk(err_code_o == 2'd0, "R10 code cleared", err_code_o, 0);
        @(negedge clk);
        chk(!cmd_valid_o, "R1 pulse width", cmd_valid_o, 0);
        chk(!dat_enable_o, "R2 data held", dat_enable_o, 0);
    endtask

    // mode: 0 ok, 1 data tmo, 2 data crc, 3 blk_end+crc
    task automatic full_write(input int len, input int code, input int addr, input int nacks, input int mode);
        int left;
        begin_write(len, code, addr);
        @(negedge clk); chk(!dat_enable_o, "R2 data held", dat_enable_o, 0);
        cmd_resp_rcvd_i = 1;
        @(negedge clk);
        cmd_resp_rcvd_i = 0;
        chk(dat_enable_o && dat_to_card_o && dat_block_mode_o, "R2 data open", dat_enable_o, 1);
        chk(dat_blk_bytes_o == 16'(exp_bytes(code)), "R3 blk bytes", dat_blk_bytes_o, exp_bytes(code));
        chk(dat_len_o == 16'(len) && cmd_arg_o == 32'(addr), "R4 held len", dat_len_o, len);
        chk(dma_burst_words_o == 3'd4, "R5 burst", dma_burst_words_o, 4);
        left = exp_words(len);
        chk(dma_req_o == (left > 0), "R5 req", dma_req_o, left > 0);
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        chk(dat_enable_o && !cmd_valid_o && busy_o, "R9 start ignored", cmd_valid_o, 0);
        for (int i = 0; i < nacks; i++) begin
            dma_ack_i = 1;
            @(negedge clk);
            dma_ack_i = 0;
            left = (left > 4) ? left - 4 : 0;
            chk(dma_req_o == (left > 0), "R5 req after ack", dma_req_o, left > 0);
        end
        case (mode)
            0: dat_blk_end_i = 1;
            1: dat_timeout_i = 1;
            2: dat_crc_err_i = 1;
            default: begin dat_blk_end_i = 1; dat_crc_err_i = 1; end
        endcase
        @(negedge clk);
        idle_inputs();
        chk(!busy_o && !dma_req_o && !dat_enable_o, "R8 back idle", busy_o, 0);
        if (mode == 0) begin
            chk(done_o && !error_o, "R6 done", done_o, 1);
            chk(err_code_o == 2'd0, "R6 code", err_code_o, 0);
        end else begin
            chk(error_o && !done_o, "R8 error", error_o, 1);
            chk(err_code_o == 2'd3, "R8 code", err_code_o, 3);
        end
        @(negedge clk);
        chk(!done_o && !error_o, "R6 pulse width", done_o | error_o, 0);
    endtask

    // mode: 0 tmo, 1 crc, 2 both, 3 resp+tmo
    task automatic cmd_fault(input int mode);
        begin_write(64, 9, 32'h1234);
        case (mode)
            0: cmd_timeout_i = 1;
            1: cmd_crc_fail_i = 1;
            2: begin cmd_timeout_i = 1; cmd_crc_fail_i = 1; end
            default: begin cmd_resp_rcvd_i = 1; cmd_timeout_i = 1; end
        endcase
        @(negedge clk);
        idle_inputs();
        chk(error_o && !busy_o && !dat_enable_o, "R7 error", error_o, 1);
        chk(err_code_o == ((mode == 1) ? 2'd2 : 2'd1), "R7 code", err_code_o, (mode == 1) ? 2 : 1);
        @(negedge clk);
        chk(!dat_enable_o && !error_o && err_code_o != 0, "R7 stays idle", dat_enable_o, 0);
    endtask

    initial begin
        int seed = 7;
        void'($urandom(seed));
        idle_inputs();
        cfg_len_i = 0; cfg_blk_code_i = 0; cfg_addr_i = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy_o && !done_o && !error_o && !cmd_valid_o && !dat_enable_o && !dma_req_o,
            "R10 reset outputs", busy_o, 0);
        chk(err_code_o == 0, "R10 reset code", err_code_o, 0);

        full_write(512, 9, 32'h0000_0200, 3, 0);
        full_write(5, 2, 32'hDEAD_0000, 2, 0);
        full_write(4, 15, 32'h1, 1, 0);
        full_write(100, 0, 32'h55, 2, 1);
        full_write(100, 7, 32'h66, 1, 2);
        full_write(64, 9, 32'h77, 0, 3);
        cmd_fault(0); cmd_fault(1); cmd_fault(2); cmd_fault(3);
        for (int t = 0; t < 40; t++) begin
            int len  = 1 + int'($urandom_range(4095));
            int code = int'($urandom_range(15));
            int nack = int'($urandom_range(6));
            int md   = int'($urandom_range(3));
            full_write(len, code, int'($urandom), nack, md);
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule